// File: doc/BRIEF.md
# Codec Command Register Engine

This block sits on the host side of a serial audio codec link and carries out one access at a time to a register inside the codec. Software fills an address register and a data register, then writes the control register with its launch bit set. The engine waits for the next frame boundary. If the link is enabled, it places the command in the two outgoing command slots of that frame and drops its busy bit.

For a read, the engine remembers which codec register it asked for. It watches each incoming frame for a status-address slot that echoes that index. When the echo arrives, the engine copies the accompanying status-data slot into a status data register and raises a valid-status flag. Software reads the flag, then the data; reading the data register lowers the flag again. The control register also holds the two link enables, which drive the link directly: one for sync generation and one for the frame-valid marker. A codec-ready input can be read back so that software can wait for the codec before it turns the frame-valid enable on.

Register indices on the bus: 0 command address, 1 command data, 2 control, 3 status, 4 status data. Control bits: bit 0 sync enable, bit 1 frame valid, bit 2 read select (1 = read), bit 3 launch/busy. Status bits: bit 0 codec ready, bit 1 valid status. Bus reads return data one cycle after the read strobe.

Top module: `acl_codec_cmd_engine`

## Requirements
- R1: After reset every register reads zero (status bit 0 still follows codec_ready), and out_cmd_tag, out_slot1, out_slot2, link_sync_en and link_frame_valid are all 0.
- R2: A control write with bit 3 set while idle starts an access: control reads back with bit 3 set and with bits 2..0 as written.
- R3: A pending command is sent only on a frame_start cycle in which control bits 0 and 1 are both set. Otherwise it stays pending, control bit 3 stays 1 and out_cmd_tag is 0 for that frame.
- R4: When a command is sent, out_cmd_tag is 1 for that frame. out_slot1 carries the read select in bit 15 and the address in bits 6..0, with bits 14..7 zero. out_slot2 carries the command data for a write and zero for a read. Control bit 3 clears at the same edge. Frames without a command show a tag of 0 and zero slots.
- R5: After a read has been sent, an in_frame pulse with in_tag1 and in_tag2 both high and in_slot1 equal to the address zero-extended loads in_slot2 into the status data register and sets status bit 1.
- R6: A response whose in_slot1 differs from the expected echo, or that lacks either tag, captures nothing. The read stays open for a later matching response.
- R7: A sent write never captures a response, even one echoing its address.
- R8: Status bit 1 clears when the status data register is read and when a new access is launched. The status data itself is kept.
- R9: While busy, writes to the address and data registers are ignored. A control write with bit 3 set is ignored entirely. A control write with bit 3 clear updates only bits 0 and 1.
- R10: Status bit 0 follows codec_ready, and link_sync_en and link_frame_valid follow control bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| codec_ready | input | 1 | Codec-up indication |
| link_sync_en | output | 1 | Sync generation enable to the link |
| link_frame_valid | output | 1 | Frame-valid marker enable to the link |
| frame_start | input | 1 | One-cycle pulse at each outgoing frame boundary |
| out_cmd_tag | output | 1 | Command slots of this frame are valid |
| out_slot1 | output | 16 | Outgoing command address slot |
| out_slot2 | output | 16 | Outgoing command data slot |
| in_frame | input | 1 | One-cycle pulse when an incoming frame is complete |
| in_tag1 | input | 1 | Incoming status-address slot valid |
| in_tag2 | input | 1 | Incoming status-data slot valid |
| in_slot1 | input | 16 | Incoming status-address slot |
| in_slot2 | input | 16 | Incoming status-data slot |

## Verification
The bench sends a launch while the link enables are off. A design that sends regardless would tag that frame; one that loses the command would never send it after the enables come on. It tries to overwrite the address, the data and the control register while a command is in flight, which catches a design that lets a late write corrupt the slots it sends. It also offers responses with a wrong echo, a missing tag, or an echo after a write. A design that matched loosely would raise valid status falsely. A design that did not keep the read open would miss the later correct echo. Finally, it checks that reading the status data, or launching anew, lowers the flag, so that stale data cannot pass as fresh.

// File: rtl/acl_pkg.sv
package acl_pkg;

  typedef enum logic [2:0] {
    RIX_ADDR  = 3'd0,
    RIX_DATA  = 3'd1,
    RIX_CTRL  = 3'd2,
    RIX_STAT  = 3'd3,
    RIX_SDATA = 3'd4
  } acl_rix_e;

  // Control register layout, LSB first: sync, frame valid, read select, busy
  typedef struct packed {
    logic busy;
    logic rd;
    logic vfrm;
    logic sync;
  } acl_ctrl_t;

  localparam int CTRL_W = $bits(acl_ctrl_t);

endpackage

// File: rtl/acl_cmd_regs.sv
module acl_cmd_regs
  import acl_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cmd_sent,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output acl_ctrl_t         ctrl,
  output logic              launch_accept
);

  logic      wr_addr, wr_data, wr_ctrl;
  acl_ctrl_t ctrl_new;

  assign wr_addr  = bus_wr && (bus_addr == RIX_ADDR);
  assign wr_data  = bus_wr && (bus_addr == RIX_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == RIX_CTRL);
  assign ctrl_new = acl_ctrl_t'(bus_wdata[CTRL_W-1:0]);

  assign launch_accept = wr_ctrl && !ctrl.busy && ctrl_new.busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_addr <= '0;
      cmd_data <= '0;
      ctrl     <= '0;
    end else begin
      if (!ctrl.busy) begin
        if (wr_addr) cmd_addr <= bus_wdata[ADDR_W-1:0];
        if (wr_data) cmd_data <= bus_wdata;
        if (wr_ctrl) ctrl     <= ctrl_new;
      end else begin
        if (wr_ctrl && !ctrl_new.busy) begin
          ctrl.sync <= ctrl_new.sync;
          ctrl.vfrm <= ctrl_new.vfrm;
        end
        if (cmd_sent) ctrl.busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/acl_tx_slots.sv
module acl_tx_slots
  import acl_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  acl_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_sent,
  output logic              out_cmd_tag,
  output logic [SLOT_W-1:0] out_slot1,
  output logic [SLOT_W-1:0] out_slot2
);

  function automatic logic [SLOT_W-1:0] addr_slot(input logic rd, input logic [ADDR_W-1:0] a);
    logic [SLOT_W-1:0] w;
    w = '0;
    w[SLOT_W-1]   = rd;
    w[ADDR_W-1:0] = a;
    return w;
  endfunction

  function automatic logic [SLOT_W-1:0] data_slot(input logic rd, input logic [DATA_W-1:0] d);
    logic [SLOT_W-1:0] w;
    w = '0;
    if (!rd) w[DATA_W-1:0] = d;
    return w;
  endfunction

  assign cmd_sent = frame_start && ctrl.busy && ctrl.vfrm && ctrl.sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_cmd_tag <= 1'b0;
      out_slot1   <= '0;
      out_slot2   <= '0;
    end else if (frame_start) begin
      out_cmd_tag <= cmd_sent;
      out_slot1   <= cmd_sent ? addr_slot(ctrl.rd, cmd_addr) : '0;
      out_slot2   <= cmd_sent ? data_slot(ctrl.rd, cmd_data) : '0;
    end
  end

endmodule

// File: rtl/acl_rx_capture.sv
module acl_rx_capture #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_sent,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              launch_accept,
  input  logic              sdata_read,
  input  logic              in_frame,
  input  logic              in_tag1,
  input  logic              in_tag2,
  input  logic [SLOT_W-1:0] in_slot1,
  input  logic [DATA_W-1:0] in_slot2,
  output logic              resp_capture,
  output logic              status_valid,
  output logic [DATA_W-1:0] status_data
);

  logic              pending;
  logic [ADDR_W-1:0] pend_addr;

  // The codec echoes the index with the read flag cleared
  function automatic logic [SLOT_W-1:0] echo_word(input logic [ADDR_W-1:0] a);
    logic [SLOT_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0] = a;
    return w;
  endfunction

  assign resp_capture = in_frame && pending && in_tag1 && in_tag2 &&
                        (in_slot1 == echo_word(pend_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending      <= 1'b0;
      pend_addr    <= '0;
      status_valid <= 1'b0;
      status_data  <= '0;
    end else begin
      if (launch_accept) begin
        pending      <= 1'b0;
        status_valid <= 1'b0;
      end else if (cmd_sent) begin
        pending   <= is_read;
        pend_addr <= cmd_addr;
      end else if (resp_capture) begin
        pending      <= 1'b0;
        status_valid <= 1'b1;
        status_data  <= in_slot2;
      end else if (sdata_read) begin
        status_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/acl_codec_cmd_engine.sv
module acl_codec_cmd_engine
  import acl_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              codec_ready,
  output logic              link_sync_en,
  output logic              link_frame_valid,
  input  logic              frame_start,
  output logic              out_cmd_tag,
  output logic [SLOT_W-1:0] out_slot1,
  output logic [SLOT_W-1:0] out_slot2,
  input  logic              in_frame,
  input  logic              in_tag1,
  input  logic              in_tag2,
  input  logic [SLOT_W-1:0] in_slot1,
  input  logic [DATA_W-1:0] in_slot2
);

  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  acl_ctrl_t         ctrl_q;
  logic              launch_accept, cmd_sent, resp_capture, sdata_read;
  logic              status_valid, ctrl_busy;
  logic [DATA_W-1:0] status_data;

  assign ctrl_busy        = ctrl_q.busy;
  assign link_sync_en     = ctrl_q.sync;
  assign link_frame_valid = ctrl_q.vfrm;
  assign sdata_read       = bus_rd && (bus_addr == RIX_SDATA);

  acl_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cmd_sent(cmd_sent), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .ctrl(ctrl_q), .launch_accept(launch_accept)
  );

  acl_tx_slots #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ctrl(ctrl_q),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sent(cmd_sent),
    .out_cmd_tag(out_cmd_tag), .out_slot1(out_slot1), .out_slot2(out_slot2)
  );

  acl_rx_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cmd_sent(cmd_sent), .is_read(ctrl_q.rd),
    .cmd_addr(cmd_addr), .launch_accept(launch_accept), .sdata_read(sdata_read),
    .in_frame(in_frame), .in_tag1(in_tag1), .in_tag2(in_tag2),
    .in_slot1(in_slot1), .in_slot2(in_slot2), .resp_capture(resp_capture),
    .status_valid(status_valid), .status_data(status_data)
  );

  function automatic logic [DATA_W-1:0] read_mux(
    input logic [2:0] idx, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
    input acl_ctrl_t c, input logic vs, input logic cr, input logic [DATA_W-1:0] sd);
    logic [DATA_W-1:0] r;
    r = '0;
    case (idx)
      RIX_ADDR:  r[ADDR_W-1:0] = a;
      RIX_DATA:  r = d;
      RIX_CTRL:  r[CTRL_W-1:0] = c;
      RIX_STAT:  r[1:0] = {vs, cr};
      RIX_SDATA: r = sd;
      default:   r = '0;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= read_mux(bus_addr, cmd_addr, cmd_data, ctrl_q,
                            status_valid, codec_ready, status_data);
  end

endmodule

// File: rtl/acl_cmd_checker.sv
module acl_cmd_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch_accept,
  input logic              cmd_sent,
  input logic              resp_capture,
  input logic              sdata_read,
  input logic              ctrl_busy,
  input logic              status_valid,
  input logic              link_sync_en,
  input logic              link_frame_valid,
  input logic              out_cmd_tag,
  input logic [ADDR_W-1:0] cmd_addr
);

  a_r2_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch_accept |=> ctrl_busy);

  a_r3_send_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sent |-> (link_sync_en && link_frame_valid && ctrl_busy));

  a_r4_busy_drops_on_send: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sent |=> !ctrl_busy);

  a_r4_tag_from_send: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_cmd_tag) |-> $past(cmd_sent));

  a_r5_capture_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_capture && !launch_accept) |=> status_valid);

  a_r8_read_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_read && !resp_capture) |=> !status_valid);

  a_r9_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_busy && $past(ctrl_busy)) |-> $stable(cmd_addr));

endmodule

bind acl_codec_cmd_engine acl_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_accept(launch_accept), .cmd_sent(cmd_sent),
  .resp_capture(resp_capture), .sdata_read(sdata_read), .ctrl_busy(ctrl_busy),
  .status_valid(status_valid), .link_sync_en(link_sync_en),
  .link_frame_valid(link_frame_valid), .out_cmd_tag(out_cmd_tag), .cmd_addr(cmd_addr)
);

// File: tb/tb_acl_codec_cmd_engine.sv
`timescale 1ns/1ps
module tb_acl_codec_cmd_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        codec_ready = 1'b0;
  logic        link_sync_en, link_frame_valid;
  logic        frame_start = 1'b0;
  logic        out_cmd_tag;
  logic [15:0] out_slot1, out_slot2;
  logic        in_frame = 1'b0, in_tag1 = 1'b0, in_tag2 = 1'b0;
  logic [15:0] in_slot1 = '0, in_slot2 = '0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  acl_codec_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .codec_ready(codec_ready), .link_sync_en(link_sync_en),
    .link_frame_valid(link_frame_valid), .frame_start(frame_start),
    .out_cmd_tag(out_cmd_tag), .out_slot1(out_slot1), .out_slot2(out_slot2),
    .in_frame(in_frame), .in_tag1(in_tag1), .in_tag2(in_tag2),
    .in_slot1(in_slot1), .in_slot2(in_slot2)
  );

  // {rw, addr[6:0], data[15:0], echo addr[6:0], echo data[15:0], capture}
  localparam logic [47:0] VECS [0:5] = '{
    {1'b1, 7'h26, 16'h0000, 7'h26, 16'hBEEF, 1'b1},
    {1'b0, 7'h02, 16'h0808, 7'h02, 16'h1234, 1'b0},
    {1'b1, 7'h7C, 16'h0000, 7'h7D, 16'h4444, 1'b0},
    {1'b1, 7'h7F, 16'h3333, 7'h7F, 16'hFFFF, 1'b1},
    {1'b0, 7'h18, 16'hA5A5, 7'h18, 16'h9999, 1'b0},
    {1'b1, 7'h00, 16'h0000, 7'h00, 16'h5A5A, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic frame_pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic resp_pulse(input logic t1, input logic t2, input logic [15:0] s1, input logic [15:0] s2);
    @(negedge clk); in_frame = 1'b1; in_tag1 = t1; in_tag2 = t2; in_slot1 = s1; in_slot2 = s2;
    @(negedge clk); in_frame = 1'b0; in_tag1 = 1'b0; in_tag2 = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      bus_read(3'(i), rd);
      chk("R1 register reset", rd, 16'h0000);
    end
    chk("R1 tag reset", {out_cmd_tag, link_sync_en, link_frame_valid}, 0);
    chk("R1 slots reset", {out_slot1, out_slot2}, 0);

    // R10 codec ready mirror
    codec_ready = 1'b1;
    bus_read(3'd3, rd);
    chk("R10 codec ready", rd, 16'h0001);

    // Vector table
    for (int v = 0; v < 6; v++) begin
      logic        rw, cap;
      logic [6:0]  a, ea;
      logic [15:0] d, ed;
      {rw, a, d, ea, ed, cap} = VECS[v];
      bus_write(3'd0, {9'h0, a});
      bus_write(3'd1, d);
      bus_write(3'd2, {12'h0, 1'b1, rw, 2'b11});
      bus_read(3'd2, rd);
      chk("R2 launch busy", rd, {12'h0, 1'b1, rw, 2'b11});
      chk("R10 link enables", {link_sync_en, link_frame_valid}, 2'b11);
      frame_pulse();
      chk("R4 tag", out_cmd_tag, 1);
      chk("R4 slot1", out_slot1, {rw, 8'h00, a});
      chk("R4 slot2", out_slot2, rw ? 16'h0000 : d);
      bus_read(3'd2, rd);
      chk("R4 busy cleared", rd, {12'h0, 1'b0, rw, 2'b11});
      resp_pulse(1'b1, 1'b1, {9'h0, ea}, ed);
      bus_read(3'd3, rd);
      chk(cap ? "R5 capture flag" : (rw ? "R6 mismatch flag" : "R7 write flag"), rd, {14'h0, cap, 1'b1});
      if (cap) begin
        bus_read(3'd4, rd);
        chk("R5 status data", rd, ed);
        bus_read(3'd3, rd);
        chk("R8 read clears flag", rd, 16'h0001);
      end
    end

    // Frames without a command carry no tag
    frame_pulse();
    chk("R4 idle frame tag", {out_cmd_tag, out_slot1, out_slot2}, 0);

    // R3 gating by link enables
    bus_write(3'd2, 16'h0009);
    frame_pulse();
    chk("R3 no send without frame valid", out_cmd_tag, 0);
    bus_read(3'd2, rd);
    chk("R3 still busy", rd, 16'h0009);
    bus_write(3'd2, 16'h0002);
    bus_read(3'd2, rd);
    chk("R9 enable update while busy", rd, 16'h000A);
    chk("R10 link outputs", {link_sync_en, link_frame_valid}, 2'b01);
    frame_pulse();
    chk("R3 no send without sync", out_cmd_tag, 0);
    bus_write(3'd2, 16'h0003);
    frame_pulse();
    chk("R3 send once enabled", out_cmd_tag, 1);

    // R9 writes ignored while busy
    bus_write(3'd0, 16'h0011);
    bus_write(3'd1, 16'h1111);
    bus_write(3'd2, 16'h000F);
    bus_write(3'd0, 16'h0022);
    bus_write(3'd1, 16'h2222);
    bus_write(3'd2, 16'h0008);
    bus_read(3'd2, rd);
    chk("R9 ctrl relaunch ignored", rd, 16'h000F);
    bus_read(3'd0, rd);
    chk("R9 addr held", rd, 16'h0011);
    bus_read(3'd1, rd);
    chk("R9 data held", rd, 16'h1111);
    frame_pulse();
    chk("R9 sent slot1", out_slot1, 16'h8011);

    // R6 missing tag, then a proper echo
    resp_pulse(1'b1, 1'b0, 16'h0011, 16'h7777);
    bus_read(3'd3, rd);
    chk("R6 missing tag", rd, 16'h0001);
    resp_pulse(1'b1, 1'b1, 16'h8011, 16'h7777);
    bus_read(3'd3, rd);
    chk("R6 echo with read flag", rd, 16'h0001);
    resp_pulse(1'b1, 1'b1, 16'h0011, 16'h7777);
    bus_read(3'd3, rd);
    chk("R5 late capture", rd, 16'h0003);

    // R8 launch clears flag, data kept; R7 write no capture
    bus_write(3'd2, 16'h000B);
    bus_read(3'd3, rd);
    chk("R8 launch clears flag", rd, 16'h0001);
    bus_read(3'd4, rd);
    chk("R8 data kept", rd, 16'h7777);
    frame_pulse();
    resp_pulse(1'b1, 1'b1, 16'h0011, 16'h6666);
    bus_read(3'd3, rd);
    chk("R7 write echo ignored", rd, 16'h0001);

    // R1 reset mid-access
    bus_write(3'd2, 16'h000F);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_read(3'd2, rd);
    chk("R1 reset clears ctrl", rd, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule